// File: doc/BRIEF.md
# Chip Select Bank Decoder

The decoder compares every bus access against twelve programmable banks. Each bank has a base word and an option word. The base word holds a base address, a set of routing attributes and a valid bit. The option word holds a mask that chooses which upper address bits take part in the compare. When an access arrives, the decoder registers the result for one cycle. That result is a one-hot chip select for the winning bank, the bank's number, and its port-size, ECC-mode, write-protect and machine-select attributes. Downstream memory machines use these attributes to route the cycle.

Software programs the banks through a simple register port. The write is synchronous and the read is combinational. A write access that lands on a write-protected bank is refused: it asserts no chip select and sets an error flag. The flag stays set until reset.

Top module: `cs_bank_decoder`

## Requirements
- R1: After the asynchronous active-low reset, every base and option word reads zero. All outputs are zero, including the error flag.
- R2: Register index bits [4:1] choose the bank and bit 0 chooses the word (0 = base, 1 = option). A base word keeps only bits 31:15, 12:5 and 0, and every other bit reads zero (keep mask 0xFFFF9FE1). An option word keeps all 32 bits. Indices 24 to 31 read zero, and writes to them change nothing.
- R3: A bank hits when base bit 0 is set and ((address XOR base) AND option) is zero over bits 31:15. An option word of zero therefore matches any address.
- R4: When several banks hit, the lowest-numbered bank wins, and `bank_o` gives its number.
- R5: Outputs are registered one cycle after an access cycle. `cs_o` is one-hot or zero. In the cycle after an idle input cycle, `cs_o` and `hit_o` are zero.
- R6: On a hit, the attribute outputs carry fields of the winning base word: `port_size_o` = bits 12:11 (1 = 8-bit, 2 = 16-bit, 3 = 32-bit), `ecc_mode_o` = bits 10:9 (0 = off, 1 = check, 2 = check and generate), `wprot_o` = bit 8, and `mach_sel_o` = bits 7:5 (0 = general purpose, 1 = flash, 3 = SDRAM, 4/5/6 = programmable machines A/B/C). On a miss, all attribute outputs are zero.
- R7: A write access whose winning bank has bit 8 set still reports `hit_o` and the attributes, but `cs_o` stays zero. `wp_err_o` goes high in the same cycle and stays high until reset. A read access to such a bank asserts its chip select normally.
- R8: An access in the same cycle as a host write is decoded against the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_idx_i | input | 5 | Register index: bank in [4:1], word select in [0] |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Combinational read data for `reg_idx_i` |
| acc_valid_i | input | 1 | Bus access present this cycle |
| acc_write_i | input | 1 | Access is a write |
| acc_addr_i | input | 32 | Access address |
| cs_o | output | 12 | One-hot chip selects, registered |
| hit_o | output | 1 | Some valid bank matched |
| bank_o | output | 4 | Number of the winning bank |
| port_size_o | output | 2 | Port-size code of the winning bank |
| ecc_mode_o | output | 2 | ECC-mode code of the winning bank |
| wprot_o | output | 1 | Write-protect bit of the winning bank |
| mach_sel_o | output | 3 | Machine-select code of the winning bank |
| wp_err_o | output | 1 | Sticky protected-write error |

## Verification
A bad stored word shows up on `reg_rdata_o` in the same cycle it is addressed. It also shows up on the decode outputs one cycle after the first access that reaches that bank. A priority or mask fault shows up as a wrong `bank_o` or a wrong chip-select bit exactly one cycle after an access where banks overlap. That is why the stimulus makes deliberately overlapping regions, an invalid bank that would otherwise win, and a zero mask. A lost or spurious error bit is caught in the cycle after the protected write, and again on every later cycle while it should stay set.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int WORD_W  = 32;
  localparam int CMP_LSB = 15;
  localparam logic [WORD_W-1:0] BASE_KEEP = 32'hFFFF_9FE1;

  typedef struct packed {
    logic [1:0] port_size;
    logic [1:0] ecc_mode;
    logic       wprot;
    logic [2:0] mach_sel;
  } bank_attr_t;

  // attribute field sits in base bits 12:5
  function automatic bank_attr_t attr_of(input logic [7:0] fld);
    bank_attr_t a;
    a.port_size = fld[7:6];
    a.ecc_mode  = fld[5:4];
    a.wprot     = fld[3];
    a.mach_sel  = fld[2:0];
    return a;
  endfunction
endpackage

// File: rtl/cs_bank_regs.sv
module cs_bank_regs
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = BANK_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic [WORD_W-1:0] base_o [NUM_BANKS],
  output logic [WORD_W-1:0] opt_o  [NUM_BANKS]
);
  logic [BANK_W-1:0] sel;
  logic              in_range;

  assign sel      = idx_i[IDX_W-1:1];
  assign in_range = int'(sel) < NUM_BANKS;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[b] <= '0;
        opt_o[b]  <= '0;
      end else if (wr_i && int'(sel) == b) begin
        if (idx_i[0]) opt_o[b]  <= wdata_i;
        else          base_o[b] <= wdata_i & BASE_KEEP;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (in_range && int'(sel) == b)
        rdata_o = idx_i[0] ? opt_o[b] : base_o[b];
    end
  end
endmodule

// File: rtl/cs_bank_match.sv
module cs_bank_match
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 12
) (
  input  logic [WORD_W-1:0]    addr_i,
  input  logic [WORD_W-1:0]    base_i [NUM_BANKS],
  input  logic [WORD_W-1:0]    opt_i  [NUM_BANKS],
  output logic [NUM_BANKS-1:0] hit_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cmp
    logic [WORD_W-1:0] diff;
    assign diff     = (addr_i ^ base_i[b]) & opt_i[b];
    assign hit_o[b] = base_i[b][0] && ((diff >> CMP_LSB) == '0);
  end
endmodule

// File: rtl/cs_prio_pick.sv
module cs_prio_pick #(
  parameter int N = 12,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic [W-1:0] idx_o,
  output logic         any_o
);
  // scan high to low so the lowest requester is written last
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int b = N - 1; b >= 0; b--) begin
      if (req_i[b]) begin
        gnt_o    = '0;
        gnt_o[b] = 1'b1;
        idx_o    = W'(b);
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/cs_bank_decoder.sv
module cs_bank_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  localparam int BANK_W = $clog2(NUM_BANKS),
  localparam int IDX_W  = BANK_W + 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_wr_i,
  input  logic [IDX_W-1:0]     reg_idx_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  input  logic                 acc_valid_i,
  input  logic                 acc_write_i,
  input  logic [WORD_W-1:0]    acc_addr_i,
  output logic [NUM_BANKS-1:0] cs_o,
  output logic                 hit_o,
  output logic [BANK_W-1:0]    bank_o,
  output logic [1:0]           port_size_o,
  output logic [1:0]           ecc_mode_o,
  output logic                 wprot_o,
  output logic [2:0]           mach_sel_o,
  output logic                 wp_err_o
);
  logic [WORD_W-1:0]    base_w [NUM_BANKS];
  logic [WORD_W-1:0]    opt_w  [NUM_BANKS];
  logic [NUM_BANKS-1:0] hit_vec, gnt;
  logic [BANK_W-1:0]    win_idx;
  logic                 any_hit;
  logic [7:0]           win_fld;
  bank_attr_t           win_attr, attr_q;
  logic                 blocked;
  logic [NUM_BANKS-1:0] cs_q;
  logic                 hit_q, err_q;
  logic [BANK_W-1:0]    bank_q;

  cs_bank_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .idx_i   (reg_idx_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (reg_rdata_o),
    .base_o  (base_w),
    .opt_o   (opt_w)
  );

  cs_bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .addr_i (acc_addr_i),
    .base_i (base_w),
    .opt_i  (opt_w),
    .hit_o  (hit_vec)
  );

  cs_prio_pick #(.N(NUM_BANKS)) u_pick (
    .req_i (hit_vec),
    .gnt_o (gnt),
    .idx_o (win_idx),
    .any_o (any_hit)
  );

  always_comb begin
    win_fld = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      if (gnt[b]) win_fld = base_w[b][12:5];
  end
  assign win_attr = attr_of(win_fld);
  assign blocked  = acc_write_i && win_attr.wprot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q   <= '0;
      hit_q  <= 1'b0;
      bank_q <= '0;
      attr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      if (acc_valid_i && any_hit) begin
        cs_q   <= blocked ? '0 : gnt;
        hit_q  <= 1'b1;
        bank_q <= win_idx;
        attr_q <= win_attr;
      end else begin
        cs_q   <= '0;
        hit_q  <= 1'b0;
        bank_q <= '0;
        attr_q <= '0;
      end
      if (acc_valid_i && any_hit && blocked) err_q <= 1'b1;
    end
  end

  assign cs_o        = cs_q;
  assign hit_o       = hit_q;
  assign bank_o      = bank_q;
  assign port_size_o = attr_q.port_size;
  assign ecc_mode_o  = attr_q.ecc_mode;
  assign wprot_o     = attr_q.wprot;
  assign mach_sel_o  = attr_q.mach_sel;
  assign wp_err_o    = err_q;

  assert_cs_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cs_o));
  assert_idle_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> (cs_o == '0 && !hit_o));
  assert_cs_needs_hit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o != '0) |-> (hit_o && cs_o[bank_o]));
  assert_bank_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (int'(bank_o) < NUM_BANKS));
  assert_prot_write_blocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> (!(hit_o && wprot_o) || (cs_o == '0 && wp_err_o)));
  assert_err_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_err_o |=> wp_err_o);
  assert_miss_attr_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (port_size_o == '0 && ecc_mode_o == '0 && !wprot_o && mach_sel_o == '0));
endmodule

// File: tb/sim_cs_bank_decoder.sv
`timescale 1ns/1ps
module sim_cs_bank_decoder;
  localparam int NB = 12;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [4:0]  reg_idx_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        acc_valid_i = 1'b0, acc_write_i = 1'b0;
  logic [31:0] acc_addr_i = '0;
  logic [NB-1:0] cs_o;
  logic        hit_o, wprot_o, wp_err_o;
  logic [3:0]  bank_o;
  logic [1:0]  port_size_o, ecc_mode_o;
  logic [2:0]  mach_sel_o;

  int checks = 0, errors = 0;

  always #5 clk_i = ~clk_i;

  cs_bank_decoder u0 (.*);

  // reference model
  logic [31:0] m_base [NB];
  logic [31:0] m_opt  [NB];
  logic [NB-1:0] e_cs;
  logic e_hit, e_wp, e_err;
  logic [3:0] e_bank;
  logic [1:0] e_ps, e_ecc;
  logic [2:0] e_ms;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NB; b++) begin m_base[b] = 0; m_opt[b] = 0; end
      e_cs = 0; e_hit = 0; e_bank = 0; e_ps = 0; e_ecc = 0; e_wp = 0; e_ms = 0; e_err = 0;
    end else begin
      int win;
      win = -1;
      if (acc_valid_i)
        for (int b = NB - 1; b >= 0; b--)
          if (m_base[b][0] && ((((acc_addr_i ^ m_base[b]) & m_opt[b]) >> 15) == 0)) win = b;
      e_cs = 0; e_hit = 0; e_bank = 0; e_ps = 0; e_ecc = 0; e_wp = 0; e_ms = 0;
      if (win >= 0) begin
        e_hit  = 1;
        e_bank = 4'(win);
        e_ps   = m_base[win][12:11];
        e_ecc  = m_base[win][10:9];
        e_wp   = m_base[win][8];
        e_ms   = m_base[win][7:5];
        if (acc_write_i && e_wp) e_err = 1;
        else e_cs[win] = 1'b1;
      end
      if (reg_wr_i && reg_idx_i < 24) begin
        if (reg_idx_i[0]) m_opt[reg_idx_i[4:1]] = reg_wdata_i;
        else m_base[reg_idx_i[4:1]] = reg_wdata_i & 32'hFFFF_9FE1;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [4:0] idx);
    if (idx >= 24) return 0;
    return idx[0] ? m_opt[idx[4:1]] : m_base[idx[4:1]];
  endfunction

  // compare against model every cycle
  always @(negedge clk_i) begin
    chk("R5", "cs_o", 32'(cs_o), 32'(e_cs));
    chk("R3", "hit_o", 32'(hit_o), 32'(e_hit));
    chk("R4", "bank_o", 32'(bank_o), 32'(e_bank));
    chk("R6", "attrs", {24'd0, port_size_o, ecc_mode_o, wprot_o, mach_sel_o},
        {24'd0, e_ps, e_ecc, e_wp, e_ms});
    chk("R7", "wp_err_o", 32'(wp_err_o), 32'(e_err));
    chk("R2", "reg_rdata_o", reg_rdata_o, m_read(reg_idx_i));
  end

  // drive one cycle; returns at the following negedge
  task automatic step(input logic wr, input logic [4:0] idx, input logic [31:0] d,
                      input logic av, input logic aw, input logic [31:0] a);
    #1;
    reg_wr_i = wr; reg_idx_i = idx; reg_wdata_i = d;
    acc_valid_i = av; acc_write_i = aw; acc_addr_i = a;
    @(negedge clk_i);
  endtask

  task automatic wreg(input int bank, input logic opt, input logic [31:0] d);
    step(1, {4'(bank), opt}, d, 0, 0, 0);
  endtask

  task automatic acc(input logic w, input logic [31:0] a);
    step(0, 0, 0, 1, w, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    for (int i = 0; i < 24; i++) begin
      step(0, 5'(i), 0, 0, 0, 0);
      chk("R1", "reset word", reg_rdata_o, 0);
    end
    chk("R1", "reset cs", 32'(cs_o), 0);
    chk("R1", "reset err", 32'(wp_err_o), 0);

    // R2 masking and zero-mask match
    wreg(3, 0, 32'hFFFF_FFFF);
    chk("R2", "base keep mask", reg_rdata_o, 32'hFFFF_9FE1);
    acc(0, 32'h1234_5678);
    chk("R3", "zero mask hits bank3", 32'(bank_o), 3);
    wreg(3, 0, 0);
    step(1, 5'd26, 32'hDEAD_BEEF, 0, 0, 0);
    chk("R2", "out of range reads zero", reg_rdata_o, 0);

    // configuration
    wreg(0, 0, 32'hF000_0801); wreg(0, 1, 32'hF000_0000);
    wreg(1, 0, 32'h2000_1800); wreg(1, 1, 32'hFFFF_8000);
    wreg(2, 0, 32'h2000_1221); wreg(2, 1, 32'hFFFF_0000);
    wreg(5, 0, 32'h2000_1C61); wreg(5, 1, 32'hF000_0000);
    wreg(7, 0, 32'h4000_0981); wreg(7, 1, 32'hFFF0_0000);
    wreg(11, 0, 32'h8000_10C1); wreg(11, 1, 32'h8000_0000);

    acc(0, 32'h2000_4000);
    chk("R4", "overlap lowest wins", 32'(bank_o), 2);
    chk("R6", "bank2 port size", 32'(port_size_o), 2);
    acc(1, 32'h2001_0000);
    chk("R4", "fallthrough to bank5", 32'(bank_o), 5);
    chk("R6", "bank5 mach sel", 32'(mach_sel_o), 3);
    acc(0, 32'hF123_4567);
    chk("R5", "bank0 cs", 32'(cs_o), 1);
    acc(0, 32'h0000_1000);
    chk("R3", "miss", 32'(hit_o), 0);
    step(0, 0, 0, 0, 0, 32'h2000_0000);
    chk("R5", "idle quiet", 32'(cs_o), 0);
    acc(0, 32'h4001_0000);
    chk("R7", "protected read cs", 32'(cs_o), 32'h80);
    chk("R7", "no error on read", 32'(wp_err_o), 0);
    acc(1, 32'h4002_0000);
    chk("R7", "protected write no cs", 32'(cs_o), 0);
    chk("R7", "protected write hit", 32'(hit_o), 1);
    chk("R7", "error set", 32'(wp_err_o), 1);
    acc(0, 32'h8000_0000);
    chk("R7", "error sticky", 32'(wp_err_o), 1);

    // R8 same-cycle write vs decode
    wreg(9, 1, 32'hFFFF_8000);
    step(1, {4'd9, 1'b0}, 32'h6000_0001, 1, 0, 32'h6000_0000);
    chk("R8", "decode uses old word", 32'(hit_o), 0);
    acc(0, 32'h6000_0000);
    chk("R8", "new word after write", 32'(bank_o), 9);

    // random traffic against model
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r, a;
      r = $urandom;
      case (r[2:0])
        0: a = 32'h2000_0000 | (r & 32'h0001_FFF8);
        1: a = 32'h4000_0000 | (r & 32'h000F_FFF0);
        2: a = 32'h6000_0000 | (r & 32'h0000_FF00);
        3: a = {1'b1, r[30:0]};
        default: a = $urandom;
      endcase
      if (r[31:28] == 0)
        step(1, 5'($urandom_range(0, 31)), $urandom, r[3], r[4], a);
      else
        step(0, 5'($urandom_range(0, 31)), 0, r[3] | r[5], r[4], a);
    end

    // R1 mid-run reset clears error flag and words
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    chk("R1", "err cleared by reset", 32'(wp_err_o), 0);
    #1 rst_ni = 1'b1;
    step(0, {4'd7, 1'b0}, 0, 0, 0, 0);
    chk("R1", "word cleared by reset", reg_rdata_o, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule